// File: doc/BRIEF.md
# Host Register Front-End for a Command-Driven SPI Controller

This block is the register interface through which a host drives a command-driven SPI controller. The host issues 32-bit reads and writes over a simple valid/ready request bus, and every read returns its data one cycle later. The block holds three internal queues:

- a command queue, fed by register writes and drained by the serial engine;
- an outgoing data queue, also fed by register writes and drained by the engine;
- an incoming data queue, filled by the engine and emptied by register reads.

The host can read the incoming queue destructively or peek at its head without removing the entry. It can also read how much free room the two outgoing queues have and how full the incoming queue is.

Four interrupt conditions are tracked: three queue watermarks and a sync event reported by the engine. Each sync event carries an 8-bit identifier, and the block keeps the most recent one. The pending bits are cleared by writing one to them. An enable mask gates the pending bits onto a single interrupt line. A soft-reset bit, set after power-on, holds the engine and the queues in reset until the host releases it.

The serial engine is outside this block. It exchanges commands and data with the block through valid/ready stream handshakes and signals sync events with a one-cycle strobe.

Top module: `spi_hostfront`

## Requirements
- R1: The request bus is always ready. A read accepted in cycle N drives `rsp_valid` high with its data in cycle N+1. Unmapped offsets read as zero.
- R2: A write to offset 0xE0 appends `req_wdata[15:0]` to the command queue. Words leave on `cmd_data` in order. A write to a full queue is dropped.
- R3: A write to offset 0xE4 appends `req_wdata[7:0]` to the outgoing data queue. Bytes leave on `sdo_data` in order. A write to a full queue is dropped.
- R4: A read at offset 0xE8 returns the oldest incoming byte and removes it. A read of an empty queue returns zero and leaves the level at zero.
- R5: A read at offset 0xEC returns the oldest incoming byte without removing it.
- R6: The free room of the command queue reads at 0xD0, the free room of the outgoing data queue at 0xD4, and the fill level of the incoming queue at 0xD8. Each queue holds 16 entries by default.
- R7: Bit 0 of offset 0x40 is the soft reset. It reads 1 after `rst_n`. While it is 1:
  - `engine_rst` is high;
  - all queues are empty;
  - pushes from the bus and from the engine are refused;
  - no stream `valid` or `ready` output is high.
  Writing 0 releases the soft reset.
- R8: Offset 0x88 reads the raw conditions:
  - bit 0: command level ≤ depth/4;
  - bit 1: outgoing data level ≤ depth/4;
  - bit 2: incoming level ≥ depth − depth/4;
  - bit 3: sync strobe in the current cycle.
- R9: Offset 0x84 reads the pending bits, using the same bit positions as R8.
  - A watermark pending bit is set in any cycle in which its condition holds.
  - The sync pending bit (bit 3) is set by a sync strobe.
  - A pending bit stays set until a write of one to it at 0x84. Writing 0xFF clears every bit whose set condition is absent in that cycle.
  - A set and a clear in the same cycle leave the bit set.
- R10: Offset 0xC0 reads the identifier carried by the most recent sync strobe. It reads zero before the first strobe.
- R11: Offset 0x80 holds a 4-bit enable mask, with the bit positions of R8. It reads zero after reset. `irq` is high exactly when some bit is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| cmd_valid | output | 1 | Command word available to the engine |
| cmd_ready | input | 1 | Engine takes the command word |
| cmd_data | output | 16 | Head command word |
| sdo_valid | output | 1 | Outgoing byte available to the engine |
| sdo_ready | input | 1 | Engine takes the outgoing byte |
| sdo_data | output | 8 | Head outgoing byte |
| sdi_valid | input | 1 | Engine offers an incoming byte |
| sdi_ready | output | 1 | Incoming queue accepts the byte |
| sdi_data | input | 8 | Incoming byte |
| sync_valid | input | 1 | One-cycle sync event strobe |
| sync_id | input | 8 | Identifier of the sync event |
| engine_rst | output | 1 | Soft reset toward the engine |
| irq | output | 1 | Interrupt line |

## Verification
The properties are checked on every cycle:

- queue levels never pass their depth;
- the soft reset silences every stream handshake;
- a sync strobe always leaves its pending bit set and its identifier stored;
- `irq` stays low under an empty mask;
- an empty-queue pop always answers zero;
- every read gets its response on the next cycle.

Only the directed scenarios can show the remaining behaviour:

- data order through each queue;
- dropping of writes to a full queue;
- the exact watermark thresholds;
- peek versus pop;
- clearing a pending bit whose condition still holds, where the bit sets again on the next cycle;
- the raw source bit for sync, which is visible only in the cycle of the strobe.

// File: rtl/spi_hostfront_pkg.sv
package spi_hostfront_pkg;
   localparam int ADDR_W = 8;
   localparam int BUS_W  = 32;
   localparam int NIRQ   = 4;

   localparam logic [ADDR_W-1:0] A_SOFTRST  = 8'h40;
   localparam logic [ADDR_W-1:0] A_IRQ_EN   = 8'h80;
   localparam logic [ADDR_W-1:0] A_IRQ_PEND = 8'h84;
   localparam logic [ADDR_W-1:0] A_IRQ_RAW  = 8'h88;
   localparam logic [ADDR_W-1:0] A_SYNC_ID  = 8'hC0;
   localparam logic [ADDR_W-1:0] A_CMD_ROOM = 8'hD0;
   localparam logic [ADDR_W-1:0] A_SDO_ROOM = 8'hD4;
   localparam logic [ADDR_W-1:0] A_SDI_LVL  = 8'hD8;
   localparam logic [ADDR_W-1:0] A_CMD_PUSH = 8'hE0;
   localparam logic [ADDR_W-1:0] A_SDO_PUSH = 8'hE4;
   localparam logic [ADDR_W-1:0] A_SDI_POP  = 8'hE8;
   localparam logic [ADDR_W-1:0] A_SDI_PEEK = 8'hEC;

   typedef enum int {
      IB_CMD_LOW  = 0,
      IB_SDO_LOW  = 1,
      IB_SDI_HIGH = 2,
      IB_SYNC     = 3
   } irq_bit_e;
endpackage

// File: rtl/spi_hf_queue.sv
module spi_hf_queue #(
   parameter int DW         = 8,
   parameter int DEPTH      = 16,
   parameter bit ZERO_EMPTY = 1'b0,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   generate
      if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
         $error("spi_hf_queue: DEPTH must be a power of two and at least 4");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;
   assign level   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   generate
      if (ZERO_EMPTY) begin : g_zero_head
         assign head = empty ? '0 : mem[rp];
      end else begin : g_raw_head
         assign head = mem[rp];
      end
   endgenerate
endmodule

// File: rtl/spi_hf_irq.sv
module spi_hf_irq #(
   parameter int NIRQ     = 4,
   parameter int SYNC_BIT = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] cond,
   input  logic            sync_evt,
   input  logic            en_we,
   input  logic [NIRQ-1:0] en_wdata,
   input  logic            clr_we,
   input  logic [NIRQ-1:0] clr_wdata,
   output logic [NIRQ-1:0] pend,
   output logic [NIRQ-1:0] en,
   output logic            irq
);
   generate
      if (SYNC_BIT >= NIRQ) begin : g_bad_bit
         $error("spi_hf_irq: SYNC_BIT out of range");
      end
   endgenerate

   logic [NIRQ-1:0] clr_mask;
   assign clr_mask = clr_we ? clr_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (en_we) en <= en_wdata;
   end

   for (genvar i = 0; i < NIRQ; i++) begin : g_pend
      logic set_i;
      if (i == SYNC_BIT) begin : g_evt
         assign set_i = sync_evt;
      end else begin : g_lvl
         assign set_i = cond[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[i] <= 1'b0;
         else        pend[i] <= set_i | (pend[i] & ~clr_mask[i]);
      end
   end

   assign irq = |(pend & en);
endmodule

// File: rtl/spi_hostfront.sv
module spi_hostfront
   import spi_hostfront_pkg::*;
#(
   parameter int CMD_DEPTH = 16,
   parameter int SDO_DEPTH = 16,
   parameter int SDI_DEPTH = 16,
   parameter int CMD_W     = 16,
   parameter int BYTE_W    = 8,
   parameter int ID_W      = 8,
   localparam int CLW = $clog2(CMD_DEPTH) + 1,
   localparam int OLW = $clog2(SDO_DEPTH) + 1,
   localparam int ILW = $clog2(SDI_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  req_wdata,
   output logic              rsp_valid,
   output logic [BUS_W-1:0]  rsp_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [CMD_W-1:0]  cmd_data,
   output logic              sdo_valid,
   input  logic              sdo_ready,
   output logic [BYTE_W-1:0] sdo_data,
   input  logic              sdi_valid,
   output logic              sdi_ready,
   input  logic [BYTE_W-1:0] sdi_data,
   input  logic              sync_valid,
   input  logic [ID_W-1:0]   sync_id,
   output logic              engine_rst,
   output logic              irq
);
   generate
      if (CMD_W > BUS_W || BYTE_W > CMD_W || ID_W > BUS_W) begin : g_bad_width
         $error("spi_hostfront: field widths exceed the bus");
      end
   endgenerate

   localparam logic [CLW-1:0] CMD_LOW  = CLW'(CMD_DEPTH / 4);
   localparam logic [OLW-1:0] SDO_LOW  = OLW'(SDO_DEPTH / 4);
   localparam logic [ILW-1:0] SDI_HIGH = ILW'(SDI_DEPTH - SDI_DEPTH / 4);

   logic wr_acc, rd_acc;
   assign req_ready = 1'b1;
   assign wr_acc    = req_valid &&  req_write;
   assign rd_acc    = req_valid && !req_write;

   logic unused_wbits;
   assign unused_wbits = ^req_wdata[BUS_W-1:CMD_W];

   // soft reset
   logic soft_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_q <= 1'b1;
      else if (wr_acc && req_addr == A_SOFTRST) soft_q <= req_wdata[0];
   end
   assign engine_rst = soft_q;

   // queues
   logic [CLW-1:0]    cmd_level;
   logic [OLW-1:0]    sdo_level;
   logic [ILW-1:0]    sdi_level;
   logic              cmd_full, cmd_empty, sdo_full, sdo_empty, sdi_full, sdi_empty;
   logic [BYTE_W-1:0] sdi_head;
   logic              sdi_pop;

   assign sdi_pop = rd_acc && req_addr == A_SDI_POP;

   spi_hf_queue #(.DW(CMD_W), .DEPTH(CMD_DEPTH), .ZERO_EMPTY(1'b0)) cmd_q_i (
      .clk(clk), .rst_n(rst_n), .clr(soft_q),
      .push(wr_acc && req_addr == A_CMD_PUSH), .din(req_wdata[CMD_W-1:0]),
      .pop(cmd_valid && cmd_ready), .head(cmd_data),
      .level(cmd_level), .full(cmd_full), .empty(cmd_empty));

   spi_hf_queue #(.DW(BYTE_W), .DEPTH(SDO_DEPTH), .ZERO_EMPTY(1'b0)) sdo_q_i (
      .clk(clk), .rst_n(rst_n), .clr(soft_q),
      .push(wr_acc && req_addr == A_SDO_PUSH), .din(req_wdata[BYTE_W-1:0]),
      .pop(sdo_valid && sdo_ready), .head(sdo_data),
      .level(sdo_level), .full(sdo_full), .empty(sdo_empty));

   spi_hf_queue #(.DW(BYTE_W), .DEPTH(SDI_DEPTH), .ZERO_EMPTY(1'b1)) sdi_q_i (
      .clk(clk), .rst_n(rst_n), .clr(soft_q),
      .push(sdi_valid && sdi_ready), .din(sdi_data),
      .pop(sdi_pop), .head(sdi_head),
      .level(sdi_level), .full(sdi_full), .empty(sdi_empty));

   assign cmd_valid = !cmd_empty && !soft_q;
   assign sdo_valid = !sdo_empty && !soft_q;
   assign sdi_ready = !sdi_full  && !soft_q;

   // interrupts
   logic [NIRQ-1:0] raw_cond, pend_q, en_q;
   assign raw_cond[IB_CMD_LOW]  = cmd_level <= CMD_LOW;
   assign raw_cond[IB_SDO_LOW]  = sdo_level <= SDO_LOW;
   assign raw_cond[IB_SDI_HIGH] = sdi_level >= SDI_HIGH;
   assign raw_cond[IB_SYNC]     = sync_valid;

   spi_hf_irq #(.NIRQ(NIRQ), .SYNC_BIT(IB_SYNC)) irq_i (
      .clk(clk), .rst_n(rst_n), .cond(raw_cond), .sync_evt(sync_valid),
      .en_we(wr_acc && req_addr == A_IRQ_EN), .en_wdata(req_wdata[NIRQ-1:0]),
      .clr_we(wr_acc && req_addr == A_IRQ_PEND), .clr_wdata(req_wdata[NIRQ-1:0]),
      .pend(pend_q), .en(en_q), .irq(irq));

   // last sync identifier
   logic [ID_W-1:0] sync_id_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sync_id_q <= '0;
      else if (sync_valid) sync_id_q <= sync_id;
   end

   // read path
   logic [BUS_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (req_addr)
         A_SOFTRST:  rd_mux = BUS_W'(soft_q);
         A_IRQ_EN:   rd_mux = BUS_W'(en_q);
         A_IRQ_PEND: rd_mux = BUS_W'(pend_q);
         A_IRQ_RAW:  rd_mux = BUS_W'(raw_cond);
         A_SYNC_ID:  rd_mux = BUS_W'(sync_id_q);
         A_CMD_ROOM: rd_mux = BUS_W'(CMD_DEPTH) - BUS_W'(cmd_level);
         A_SDO_ROOM: rd_mux = BUS_W'(SDO_DEPTH) - BUS_W'(sdo_level);
         A_SDI_LVL:  rd_mux = BUS_W'(sdi_level);
         A_SDI_POP,
         A_SDI_PEEK: rd_mux = BUS_W'(sdi_head);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_acc;
         if (rd_acc) rsp_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/spi_hostfront_chk.sv
module spi_hostfront_chk #(
   parameter int CMD_DEPTH = 16,
   parameter int SDO_DEPTH = 16,
   parameter int SDI_DEPTH = 16,
   parameter int CLW = 5,
   parameter int OLW = 5,
   parameter int ILW = 5,
   parameter int ID_W = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_write,
   input logic [7:0]     req_addr,
   input logic           rsp_valid,
   input logic [31:0]    rsp_rdata,
   input logic           cmd_valid,
   input logic           sdo_valid,
   input logic           sdi_ready,
   input logic           sync_valid,
   input logic [ID_W-1:0] sync_id,
   input logic           irq,
   input logic           soft_q,
   input logic [CLW-1:0] cmd_level,
   input logic [OLW-1:0] sdo_level,
   input logic [ILW-1:0] sdi_level,
   input logic [3:0]     pend_q,
   input logic [3:0]     en_q,
   input logic [ID_W-1:0] sync_id_q
);
   // R2
   cmd_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_level <= CLW'(CMD_DEPTH));
   // R3
   sdo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_level <= OLW'(SDO_DEPTH));
   // R4
   sdi_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdi_level <= ILW'(SDI_DEPTH));
   // R4
   empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == 8'hE8 && sdi_level == '0) |=> (rsp_rdata == 32'd0));
   // R7
   soft_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_q |-> (!cmd_valid && !sdo_valid && !sdi_ready));
   // R9
   sync_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_valid |=> pend_q[3]);
   // R10
   sync_id_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_valid |=> (sync_id_q == $past(sync_id)));
   // R11
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 4'd0) |-> !irq);
   // R1
   read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
endmodule

bind spi_hostfront spi_hostfront_chk #(
   .CMD_DEPTH(CMD_DEPTH), .SDO_DEPTH(SDO_DEPTH), .SDI_DEPTH(SDI_DEPTH),
   .CLW(CLW), .OLW(OLW), .ILW(ILW), .ID_W(ID_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .cmd_valid(cmd_valid), .sdo_valid(sdo_valid), .sdi_ready(sdi_ready),
   .sync_valid(sync_valid), .sync_id(sync_id), .irq(irq), .soft_q(soft_q),
   .cmd_level(cmd_level), .sdo_level(sdo_level), .sdi_level(sdi_level),
   .pend_q(pend_q), .en_q(en_q), .sync_id_q(sync_id_q));

// File: tb/spi_hostfront_tb.sv
`timescale 1ns/1ps
module spi_hostfront_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic        cmd_valid, cmd_ready = 1'b0;
   logic [15:0] cmd_data;
   logic        sdo_valid, sdo_ready = 1'b0;
   logic [7:0]  sdo_data;
   logic        sdi_valid = 1'b0, sdi_ready;
   logic [7:0]  sdi_data = '0;
   logic        sync_valid = 1'b0;
   logic [7:0]  sync_id = '0;
   logic        engine_rst, irq;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   spi_hostfront dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
      .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
      .sdi_valid(sdi_valid), .sdi_ready(sdi_ready), .sdi_data(sdi_data),
      .sync_valid(sync_valid), .sync_id(sync_id),
      .engine_rst(engine_rst), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rsp_rdata;
      chk("R1 rsp_valid", 32'(rsp_valid), 32'd1);
   endtask

   task automatic sdi_push(input logic [7:0] b);
      @(negedge clk);
      sdi_valid = 1'b1; sdi_data = b;
      @(negedge clk);
      sdi_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R7 engine_rst after reset", 32'(engine_rst), 32'd1);
      chk("R7 cmd_valid held", 32'(cmd_valid), 32'd0);
      chk("R7 sdi_ready held", 32'(sdi_ready), 32'd0);
      chk("R1 req_ready", 32'(req_ready), 32'd1);
      bus_rd(8'h40, d); chk("R7 soft reset reads 1", d, 32'd1);
      bus_rd(8'h80, d); chk("R11 enable resets 0", d, 32'd0);
      bus_rd(8'hC0, d); chk("R10 id resets 0", d, 32'd0);
      bus_wr(8'hE0, 32'h1234);
      bus_wr(8'h40, 32'd0);
      chk("R7 engine_rst released", 32'(engine_rst), 32'd0);
      bus_rd(8'hD0, d); chk("R7 push during reset dropped", d, 32'd16);
      bus_rd(8'hD4, d); chk("R6 sdo room", d, 32'd16);
      bus_rd(8'hD8, d); chk("R6 sdi level", d, 32'd0);
      bus_rd(8'h50, d); chk("R1 unmapped zero", d, 32'd0);
   endtask

   task automatic t_cmd_queue();
      logic [31:0] d;
      for (int i = 0; i < 17; i++) bus_wr(8'hE0, 32'hABCD_0000 | 32'(16'h100 + i));
      bus_rd(8'hD0, d); chk("R6 cmd room full", d, 32'd0);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         chk("R2 cmd_valid", 32'(cmd_valid), 32'd1);
         chk("R2 cmd order", 32'(cmd_data), 32'(16'h100 + i));
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
      end
      chk("R2 overflow dropped", 32'(cmd_valid), 32'd0);
      bus_rd(8'hD0, d); chk("R6 cmd room empty", d, 32'd16);
   endtask

   task automatic t_sdo_queue();
      logic [31:0] d;
      bus_wr(8'hE4, 32'h1A5);
      bus_wr(8'hE4, 32'h03C);
      bus_rd(8'hD4, d); chk("R6 sdo room 14", d, 32'd14);
      @(negedge clk);
      chk("R3 sdo first", 32'(sdo_data), 32'hA5);
      sdo_ready = 1'b1;
      @(negedge clk);
      chk("R3 sdo second", 32'(sdo_data), 32'h3C);
      @(negedge clk);
      sdo_ready = 1'b0;
      chk("R3 sdo drained", 32'(sdo_valid), 32'd0);
   endtask

   task automatic t_sdi_queue();
      logic [31:0] d;
      sdi_push(8'h11); sdi_push(8'h22); sdi_push(8'h33);
      bus_rd(8'hD8, d);  chk("R6 sdi level 3", d, 32'd3);
      bus_rd(8'hEC, d);  chk("R5 peek head", d, 32'h11);
      bus_rd(8'hD8, d);  chk("R5 peek keeps level", d, 32'd3);
      bus_rd(8'hE8, d);  chk("R4 pop first", d, 32'h11);
      bus_rd(8'hE8, d);  chk("R4 pop second", d, 32'h22);
      bus_rd(8'hE8, d);  chk("R4 pop third", d, 32'h33);
      bus_rd(8'hE8, d);  chk("R4 empty pop zero", d, 32'd0);
      bus_rd(8'hD8, d);  chk("R4 no underflow", d, 32'd0);
   endtask

   task automatic t_watermarks();
      logic [31:0] d;
      for (int i = 0; i < 4; i++) bus_wr(8'hE0, 32'(i));
      bus_rd(8'h88, d); chk("R8 cmd level 4 is low", d & 32'h1, 32'h1);
      bus_wr(8'hE0, 32'd4);
      bus_rd(8'h88, d); chk("R8 cmd level 5 not low", d & 32'h1, 32'h0);
      bus_wr(8'h84, 32'h1);
      bus_rd(8'h84, d); chk("R9 cmd pending cleared", d & 32'h1, 32'h0);
      for (int i = 0; i < 11; i++) sdi_push(8'(i));
      bus_rd(8'h88, d); chk("R8 sdi 11 not high", d & 32'h4, 32'h0);
      sdi_push(8'hFF);
      bus_rd(8'h88, d); chk("R8 sdi 12 high", d & 32'h4, 32'h4);
      bus_wr(8'h84, 32'h4);
      bus_rd(8'h84, d); chk("R9 level pending sets again", d & 32'h4, 32'h4);
      bus_wr(8'h40, 32'd1);
      bus_wr(8'h40, 32'd0);
      bus_rd(8'hD0, d); chk("R7 soft reset clears cmd", d, 32'd16);
      bus_rd(8'hD8, d); chk("R7 soft reset clears sdi", d, 32'd0);
      bus_wr(8'h84, 32'hFF);
      bus_rd(8'h84, d); chk("R9 all-clear keeps live levels", d, 32'h3);
   endtask

   task automatic t_sync_irq();
      logic [31:0] d;
      bus_wr(8'h80, 32'h8);
      bus_rd(8'h80, d); chk("R11 enable readback", d, 32'h8);
      chk("R11 irq low without sync", 32'(irq), 32'd0);
      @(negedge clk);
      sync_valid = 1'b1; sync_id = 8'h5A;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h88;
      @(negedge clk);
      sync_valid = 1'b0; req_valid = 1'b0;
      chk("R8 raw sync bit", rsp_rdata, 32'hB);
      chk("R11 irq on sync", 32'(irq), 32'd1);
      bus_rd(8'hC0, d); chk("R10 id stored", d, 32'h5A);
      bus_rd(8'h84, d); chk("R9 sync pending held", d, 32'hB);
      bus_wr(8'h84, 32'h8);
      chk("R11 irq cleared", 32'(irq), 32'd0);
      bus_rd(8'h84, d); chk("R9 w1c sync", d, 32'h3);
      bus_wr(8'h80, 32'h1);
      chk("R11 irq from cmd low", 32'(irq), 32'd1);
      bus_wr(8'h80, 32'h0);
      chk("R11 irq masked", 32'(irq), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd_queue();
      t_sdo_queue();
      t_sdi_queue();
      t_watermarks();
      t_sync_irq();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule